// File: doc/BRIEF.md
# Pin Controller with Edge-Event Interrupts

This block controls thirteen general-purpose pins from a small byte-wide register bus. Every pin owns two registers. The first is a drive register. It sets the output value, the direction, push-pull versus open-drain drive, and the pull enable and pull selection. The second is a sense register. It reports the synchronized pin level and holds a two-bit code that picks which transitions count as events.

Pin inputs pass through a two-flop synchronizer. An edge detector compares the synchronized level with its value from the previous cycle. When a selected edge is seen, the pin's pending bit is latched into one of two status groups. Each status group has a mask register beside it. A single registered interrupt line stays high while any pending bit that is not masked remains set. The host reads the status registers, clears the bits it has handled by writing ones, and reads again until nothing is pending.

Top module: `pgio_top`

## Requirements
- R1: Register map on `bus_addr`: drive registers of pins 0..12 at 0..12, sense registers at 13..25, status group A at 26, status group B at 27, mask A at 28, mask B at 29. A read strobe at one clock edge presents the data on `bus_rdata` from that edge on.
- R2: Drive register layout: bit 0 is the value on `pin_out`, bits 2:1 appear on that pin's `pin_pull_sel` slice, bit 3 is `pin_pull_en`, bit 4 = 1 selects push-pull (`pin_od` = 0) and 0 selects open-drain (`pin_od` = 1), and bit 5 = 1 makes the pin an output. Bits 7:6 read as zero.
- R3: With push-pull drive, `pin_oe` equals the direction bit. With open-drain drive, `pin_oe` is 1 only when the direction bit is 1 and the value bit is 0.
- R4: Sense register: bit 0 reads the synchronized pin level, and writes to it are ignored. Bits 2:1 hold the detect code and read back as written. Bits 7:3 read as zero.
- R5: Detect code 0 gives no events, 1 gives falling edges, 2 gives rising edges and 3 gives both. A qualifying pin change latches its status bit; a read issued three clocks after the change sees it.
- R6: Pins 0..6 map to status group A bits 0..6. Pin 7+n maps to status group B bit n (n = 0..5). Unused upper bits of status and mask registers read as zero.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R8: Status bits latch whatever the mask. `irq` is high, one clock after the status, exactly when some status bit has a mask bit of 0. A mask bit of 1 blocks that pin.
- R9: After reset every drive and sense register is zero, status is zero, both masks are all ones (0x7F and 0x3F), and `irq` is 0.
- R10: Reads of addresses 30 and above return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 13 | Pin input levels (asynchronous) |
| pin_out | output | 13 | Output value per pin |
| pin_oe | output | 13 | Pad drive enable per pin |
| pin_od | output | 13 | Open-drain mode per pin |
| pin_pull_en | output | 13 | Pull enable per pin |
| pin_pull_sel | output | 26 | Pull selection, two bits per pin (pin i at 2i+1:2i) |
| irq | output | 1 | Interrupt, high while an unmasked event is pending |

## Verification
The bench builds the block with its defaults: thirteen pins split 7/6 and a six-bit address. This places the group boundary between pins 6 and 7, and puts the first unmapped address at 30. It can therefore probe both group edges and the unused bits of group B. Seeded random pin toggles, detect codes, masks and clearing writes are checked against a bench model. A directed case times a clearing write onto the exact cycle in which an edge lands.

// File: rtl/pgio_pkg.sv
package pgio_pkg;
  typedef enum logic [1:0] {
    DET_OFF  = 2'd0,
    DET_FALL = 2'd1,
    DET_RISE = 2'd2,
    DET_BOTH = 2'd3
  } det_mode_e;

  // drive register, bit 5 down to bit 0
  typedef struct packed {
    logic       dir;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       val;
  } drv_cfg_t;
endpackage

// File: rtl/pgio_pin.sv
module pgio_pin
  import pgio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_drv,
  input  logic       wr_sense,
  input  logic [5:0] wdata,
  input  logic       pin_in,
  output drv_cfg_t   drv,
  output det_mode_e  det,
  output logic       level,
  output logic       evt,
  output logic       pad_oe
);
  logic sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv   <= '0;
      det   <= DET_OFF;
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (wr_drv)   drv <= drv_cfg_t'(wdata);
      if (wr_sense) det <= det_mode_e'(wdata[2:1]);
    end
  end

  assign level = sync2;

  always_comb begin
    case (det)
      DET_FALL: evt = prev & ~sync2;
      DET_RISE: evt = ~prev & sync2;
      DET_BOTH: evt = prev ^ sync2;
      default:  evt = 1'b0;
    endcase
  end

  // open-drain only pulls low; push-pull follows direction
  assign pad_oe = drv.push_pull ? drv.dir : (drv.dir & ~drv.val);
endmodule

// File: rtl/pgio_evt_group.sv
module pgio_evt_group #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         pend
);
  logic [W-1:0] clr;

  assign clr = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      mask <= '1;
    end else begin
      stat <= (stat & ~clr) | evt;
      if (wr_mask) mask <= wdata;
    end
  end

  assign pend = |(stat & ~mask);
endmodule

// File: rtl/pgio_top.sv
module pgio_top
  import pgio_pkg::*;
#(
  parameter int NUM_PINS  = 13,
  parameter int GRP_A_W   = 7,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_od,
  output logic [NUM_PINS-1:0]   pin_pull_en,
  output logic [2*NUM_PINS-1:0] pin_pull_sel,
  output logic                  irq
);
  localparam int GRP_B_W    = NUM_PINS - GRP_A_W;
  localparam int DRV_BASE   = 0;
  localparam int SENSE_BASE = NUM_PINS;
  localparam int STAT_A     = 2 * NUM_PINS;
  localparam int STAT_B     = STAT_A + 1;
  localparam int MASK_A     = STAT_A + 2;
  localparam int MASK_B     = STAT_A + 3;

  drv_cfg_t              drv   [NUM_PINS];
  det_mode_e             det   [NUM_PINS];
  logic [NUM_PINS-1:0]   level;
  logic [NUM_PINS-1:0]   evt;
  logic [GRP_A_W-1:0]    stat_a, mask_a;
  logic [GRP_B_W-1:0]    stat_b, mask_b;
  logic                  pend_a, pend_b;
  logic [DATA_W-1:0]     rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int loc);
    return int'(a) == loc;
  endfunction

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pgio_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .wr_drv   (bus_wr && hit(bus_addr, DRV_BASE + i)),
      .wr_sense (bus_wr && hit(bus_addr, SENSE_BASE + i)),
      .wdata    (bus_wdata[5:0]),
      .pin_in   (pin_in[i]),
      .drv      (drv[i]),
      .det      (det[i]),
      .level    (level[i]),
      .evt      (evt[i]),
      .pad_oe   (pin_oe[i])
    );
    assign pin_out[i]            = drv[i].val;
    assign pin_od[i]             = ~drv[i].push_pull;
    assign pin_pull_en[i]        = drv[i].pull_en;
    assign pin_pull_sel[2*i+1:2*i] = drv[i].pull_sel;
  end

  pgio_evt_group #(.W(GRP_A_W)) u_grp_a (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt[GRP_A_W-1:0]),
    .wr_stat (bus_wr && hit(bus_addr, STAT_A)),
    .wr_mask (bus_wr && hit(bus_addr, MASK_A)),
    .wdata   (bus_wdata[GRP_A_W-1:0]),
    .stat    (stat_a),
    .mask    (mask_a),
    .pend    (pend_a)
  );

  pgio_evt_group #(.W(GRP_B_W)) u_grp_b (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt[NUM_PINS-1:GRP_A_W]),
    .wr_stat (bus_wr && hit(bus_addr, STAT_B)),
    .wr_mask (bus_wr && hit(bus_addr, MASK_B)),
    .wdata   (bus_wdata[GRP_B_W-1:0]),
    .stat    (stat_b),
    .mask    (mask_b),
    .pend    (pend_b)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (hit(bus_addr, DRV_BASE + i))   rd_mux = DATA_W'(drv[i]);
      if (hit(bus_addr, SENSE_BASE + i)) rd_mux = DATA_W'({det[i], level[i]});
    end
    if (hit(bus_addr, STAT_A)) rd_mux = DATA_W'(stat_a);
    if (hit(bus_addr, STAT_B)) rd_mux = DATA_W'(stat_b);
    if (hit(bus_addr, MASK_A)) rd_mux = DATA_W'(mask_a);
    if (hit(bus_addr, MASK_B)) rd_mux = DATA_W'(mask_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= pend_a | pend_b;
    end
  end
endmodule

// File: rtl/pgio_chk.sv
module pgio_chk #(
  parameter int NUM_PINS = 13,
  parameter int GRP_A_W  = 7,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [NUM_PINS-1:0]           pin_out,
  input logic [NUM_PINS-1:0]           pin_oe,
  input logic [NUM_PINS-1:0]           pin_od,
  input logic                          irq,
  input logic [GRP_A_W-1:0]            stat_a,
  input logic [NUM_PINS-GRP_A_W-1:0]   stat_b
);
  localparam int LAST_ADDR = 2 * NUM_PINS + 3;

  // R3
  od_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_od & pin_out) & pin_oe) == '0);

  // R7
  stat_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  // R7
  stat_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ((stat_b & $past(stat_b)) == $past(stat_b)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_a == '0 && stat_b == '0) |=> !irq);

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) > LAST_ADDR) |=> (bus_rdata == '0));

  // R6
  grp_b_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) == 2 * NUM_PINS + 1) |=>
      (bus_rdata[DATA_W-1:NUM_PINS-GRP_A_W] == '0));
endmodule

bind pgio_top pgio_chk #(
  .NUM_PINS (NUM_PINS),
  .GRP_A_W  (GRP_A_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_od    (pin_od),
  .irq       (irq),
  .stat_a    (stat_a),
  .stat_b    (stat_b)
);

// File: tb/pgio_top_tb.sv
module pgio_top_tb;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_od, pin_pull_en;
  logic [2*N-1:0] pin_pull_sel;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  logic [1:0]   m_det [N];
  logic [N-1:0] m_stat = '0;
  logic [6:0]   m_mask_a = 7'h7F;
  logic [5:0]   m_mask_b = 6'h3F;

  always #10 clk = ~clk;

  pgio_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
    .pin_pull_en(pin_pull_en), .pin_pull_sel(pin_pull_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = 6'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic edge_hit(input logic [1:0] code, input logic o, input logic n);
    case (code)
      2'd1: return o & ~n;
      2'd2: return ~o & n;
      2'd3: return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_oe(input logic [7:0] v);
    return v[4] ? v[5] : (v[5] & ~v[0]);
  endfunction

  function automatic logic exp_irq();
    return |(m_stat[6:0] & ~m_mask_a) | |(m_stat[12:7] & ~m_mask_b);
  endfunction

  task automatic chk_stat(input string req);
    logic [7:0] d;
    rd(26, d); chk(req, d, {1'b0, m_stat[6:0]});
    rd(27, d); chk(req, d, {2'b0, m_stat[12:7]});
  endtask

  task automatic toggle(input int p);
    logic o;
    o = pin_in[p];
    pin_in[p] = ~o;
    repeat (4) @(negedge clk);
    if (edge_hit(m_det[p], o, ~o)) m_stat[p] = 1'b1;
  endtask

  initial begin : main
    logic [7:0] d, v;
    logic [7:0] pads;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    for (int i = 0; i < N; i++) begin
      rd(i, d);     chk("R9 drive reset", d, 8'h00);
      rd(N + i, d); chk("R9 sense reset", d, 8'h00);
    end
    rd(28, d); chk("R9 mask A reset", d, 8'h7F);
    rd(29, d); chk("R9 mask B reset", d, 8'h3F);
    chk_stat("R9 status reset");
    chk("R9 irq reset", {7'b0, irq}, 8'h00);
    chk("R9 oe reset", {7'b0, |pin_oe}, 8'h00);

    // R1 R2 R3 drive registers and pads
    for (int i = 0; i < N; i++) begin
      v = 8'($urandom());
      if (i == 0) v = 8'h21;
      if (i == 1) v = 8'h20;
      if (i == 2) v = 8'h31;
      wr(i, v);
      rd(i, d); chk("R1 R2 drive readback", d, {2'b0, v[5:0]});
      pads = {2'b0, pin_out[i], pin_oe[i], pin_od[i], pin_pull_en[i], pin_pull_sel[2*i+1 -: 2]};
      chk("R2 R3 pad outputs", pads, {2'b0, v[0], exp_oe(v), ~v[4], v[3], v[2:1]});
    end

    // R4 sense register: bit 0 not writable, code readback
    for (int i = 0; i < N; i++) begin
      m_det[i] = 2'($urandom());
      if (i == 6 || i == 7) m_det[i] = 2'd3;
      wr(N + i, {5'h1F, m_det[i], 1'b1});
      rd(N + i, d); chk("R4 sense readback", d, {5'b0, m_det[i], 1'b0});
    end
    pin_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    if (edge_hit(m_det[5], 1'b0, 1'b1)) m_stat[5] = 1'b1;
    rd(N + 5, d); chk("R4 level readback", d, {5'b0, m_det[5], 1'b1});

    // R6 group boundary pins
    toggle(6); toggle(7);
    chk_stat("R6 group boundary");

    // R5 R6 R7 R8 random pin activity, clears and masks
    for (int it = 0; it < 80; it++) begin
      int p;
      p = int'($urandom() % N);
      toggle(p);
      if (it % 7 == 3) begin
        v = 8'($urandom());
        if ($urandom() % 2 == 0) begin
          wr(26, v); m_stat[6:0] = m_stat[6:0] & ~v[6:0];
        end else begin
          wr(27, v); m_stat[12:7] = m_stat[12:7] & ~v[5:0];
        end
      end
      if (it % 11 == 5) begin
        v = 8'($urandom());
        wr(28, v); m_mask_a = v[6:0];
        v = 8'($urandom());
        wr(29, v); m_mask_b = v[5:0];
      end
      @(negedge clk);
      chk_stat("R5 R6 R7 status");
      chk("R8 irq", {7'b0, irq}, {7'b0, exp_irq()});
    end

    // R8 status latches while masked; irq follows unmask
    wr(28, 8'h7F); m_mask_a = 7'h7F;
    wr(29, 8'h3F); m_mask_b = 7'h3F;
    wr(26, 8'h7F); wr(27, 8'h3F); m_stat = '0;
    wr(N + 3, 8'h04); m_det[3] = 2'd2;
    pin_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    toggle(3);
    pin_in[3] = 1'b1;
    chk_stat("R8 masked status latches");
    @(negedge clk);
    chk("R8 masked irq low", {7'b0, irq}, 8'h00);
    wr(28, 8'h77); m_mask_a = 7'h77;
    @(negedge clk);
    chk("R8 unmasked irq high", {7'b0, irq}, 8'h01);

    // R7 writing zero leaves status
    wr(26, 8'h00);
    rd(26, d); chk("R7 write zero keeps", d, 8'h08);
    wr(26, 8'h08);
    rd(26, d); chk("R7 write one clears", d, 8'h00);

    // R7 collision: edge and clear in the same cycle
    pin_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    pin_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(26, 8'h08);
    rd(26, d); chk("R7 edge beats clear", d, 8'h08);

    // R10 unmapped addresses
    rd(30, d); chk("R10 unmapped read", d, 8'h00);
    rd(63, d); chk("R10 unmapped read high", d, 8'h00);
    wr(30, 8'hFF); wr(31, 8'hFF); wr(45, 8'hFF);
    rd(28, d); chk("R10 mask A untouched", d, 8'h77);
    rd(29, d); chk("R10 mask B untouched", d, 8'h3F);
    rd(26, d); chk("R10 status untouched", d, 8'h08);
    rd(0, d);  chk("R10 drive untouched", d, 8'h21);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule